// File: doc/BRIEF.md
# Flash segment access guard

This block sits in front of a flash array and judges every read request a bus master sends toward it. The flash offset range is cut into equal segments, 32 or 64 of them, chosen by a parameter. Each segment carries two protection bits. The first limits the segment to instruction fetches. The second limits it to privileged (supervisor) code. A request that passes both rules starts a flash read in the same cycle. A request that breaks either rule starts no read, and its response carries an error flag with all-zero data.

The protection masks are taken from input ports while reset is held and stay fixed afterwards. A small read-only register window on a 32-bit peripheral bus exposes both masks and a configuration word. The bus uses a setup phase followed by an access phase. Writes are accepted but change nothing, and offsets beyond the last register answer with a slave error.

Top module: `flash_seg_guard`

## Requirements
- R1: The segment of a request is the top log2(SEG_COUNT) bits of `req_addr`, so each segment spans FLASH_BYTES/SEG_COUNT bytes. SEG_COUNT is 32 or 64.
- R2: When the fetch-only bit of the segment is set, a request with `req_fetch`=1 is allowed and a request with `req_fetch`=0 (data read) is denied.
- R3: When the privileged-only bit of the segment is set, a request with `req_priv`=0 is denied. With `req_priv`=1 only R2 decides.
- R4: Each request cycle produces `rsp_valid`=1 exactly one cycle later, and requests may come back to back. An allowed request answers with `rsp_err`=0 and the data the flash returned for it.
- R5: A denied request keeps `fl_rd_en` low in its request cycle. Its response has `rsp_err`=1 and `rsp_data`=0.
- R6: Both masks are loaded from `cfg_fetch_only` and `cfg_priv_only` on every clock while `rst_n` is low. Changes on those ports after reset have no effect.
- R7: Register reads in the access phase return the following. 0x18 gives fetch-only mask bits 63..32. 0x1C gives fetch-only bits 31..0. 0x20 gives privileged-only bits 63..32. 0x24 gives privileged-only bits 31..0. 0x28 gives the configuration word, with the segment count in bits 7..0 and log2 of the segment size in bytes in bits 20..16. Other offsets up to 0x2B read zero. With 32 segments, both high words read zero.
- R8: Any access, read or write, whose setup-phase `paddr` is above 0x2B raises `pslverr` in its access phase with `prdata`=0.
- R9: A register write changes no register and returns `prdata`=0.
- R10: While reset is held, `rsp_valid`, `rsp_err`, `rsp_data` and `pslverr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fetch_only | input | SEG_COUNT | Fetch-only mask, sampled during reset |
| cfg_priv_only | input | SEG_COUNT | Privileged-only mask, sampled during reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Flash byte offset |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| fl_rd_en | output | 1 | Start a flash read |
| fl_addr | output | ADDR_W | Flash read offset |
| fl_rdata | input | 32 | Flash data, one cycle after `fl_rd_en` |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is a protection error |
| rsp_data | output | 32 | Response data |
| psel | input | 1 | Register window select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write access |
| paddr | input | 8 | Register byte offset |
| prdata | output | 32 | Register read data |
| pslverr | output | 1 | Register access error |

## Verification
A corrupted mask bit stays hidden until its segment is used. It then shows one cycle after the request as a wrong `rsp_err`, and in the same cycle as a wrong `fl_rd_en`. It also shows directly in the access phase of a read of the matching mask word. A stuck response flag appears at the first idle cycle that follows a request, as a spurious or missing `rsp_valid`. The vectors therefore reach both edges of the high-word segments and both privilege and fetch combinations on every protected segment. A 32-segment instance checks that its high words read zero.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    // Highest byte offset of the register window that is answered without error.
    localparam int unsigned WIN_LAST_BYTE = 'h2B;

    // Word indices (byte offset / 4) of the readable registers.
    localparam int unsigned WI_FETCH_HI = 'h18 >> 2;
    localparam int unsigned WI_FETCH_LO = 'h1C >> 2;
    localparam int unsigned WI_PRIV_HI  = 'h20 >> 2;
    localparam int unsigned WI_PRIV_LO  = 'h24 >> 2;
    localparam int unsigned WI_CONFIG   = 'h28 >> 2;

    // Configuration word: segment count in [7:0], log2 segment bytes in [20:16].
    function automatic logic [31:0] config_word(input int unsigned seg_count,
                                                input int unsigned seg_log2);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = 8'(seg_count);
        w[20:16] = 5'(seg_log2);
        return w;
    endfunction

endpackage

// File: rtl/seg_rule_check.sv
module seg_rule_check #(
    parameter int unsigned SEG_COUNT = 64,
    localparam int unsigned SEG_W = $clog2(SEG_COUNT)
) (
    input  logic [SEG_W-1:0]     seg_idx,
    input  logic                 is_fetch,
    input  logic                 is_priv,
    input  logic [SEG_COUNT-1:0] fetch_only,
    input  logic [SEG_COUNT-1:0] priv_only,
    output logic                 deny
);
    logic hit_fetch_only;
    logic hit_priv_only;

    always_comb begin
        hit_fetch_only = fetch_only[seg_idx];
        hit_priv_only  = priv_only[seg_idx];
        // data reads are refused in fetch-only segments; user code in privileged ones
        deny = (hit_fetch_only && !is_fetch) || (hit_priv_only && !is_priv);
    end
endmodule

// File: rtl/seg_reg_window.sv
module seg_reg_window
    import seg_guard_pkg::*;
#(
    parameter int unsigned SEG_COUNT   = 64,
    parameter int unsigned FLASH_BYTES = 65536,
    parameter int unsigned PADDR_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEG_COUNT-1:0] fetch_only,
    input  logic [SEG_COUNT-1:0] priv_only,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [PADDR_W-1:0]   paddr,
    output logic [31:0]          prdata,
    output logic                 pslverr
);
    localparam int unsigned SEG_LOG2 = $clog2(FLASH_BYTES / SEG_COUNT);
    localparam logic [31:0] CFG_WORD = config_word(SEG_COUNT, SEG_LOG2);

    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
    } win_state_t;

    win_state_t win_d, win_q;
    logic [31:0] fo_hi, fo_lo, po_hi, po_lo;
    logic [31:0] sel_word;
    logic        access_ph;

    generate
        if (SEG_COUNT > 32) begin : g_wide
            assign fo_hi = fetch_only[SEG_COUNT-1:32];
            assign po_hi = priv_only[SEG_COUNT-1:32];
        end else begin : g_narrow
            assign fo_hi = '0;
            assign po_hi = '0;
        end
    endgenerate
    assign fo_lo = fetch_only[31:0];
    assign po_lo = priv_only[31:0];

    always_comb begin
        case (int'(paddr[PADDR_W-1:2]))
            WI_FETCH_HI: sel_word = fo_hi;
            WI_FETCH_LO: sel_word = fo_lo;
            WI_PRIV_HI:  sel_word = po_hi;
            WI_PRIV_LO:  sel_word = po_lo;
            WI_CONFIG:   sel_word = CFG_WORD;
            default:     sel_word = '0;
        endcase
    end

    always_comb begin
        win_d = win_q;
        if (!rst_n) begin
            win_d = '0;
        end else if (psel && !penable) begin
            win_d.err   = (paddr > PADDR_W'(WIN_LAST_BYTE));
            win_d.rdata = (pwrite || win_d.err) ? '0 : sel_word;
        end
    end

    always_ff @(posedge clk) begin
        win_q <= win_d;
    end

    assign access_ph = psel && penable;
    assign prdata    = access_ph ? win_q.rdata : '0;
    assign pslverr   = access_ph && win_q.err;

    // R8
    err_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> ($past(paddr) > PADDR_W'(WIN_LAST_BYTE)));
    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (prdata == '0));
endmodule

// File: rtl/flash_seg_guard.sv
module flash_seg_guard #(
    parameter int unsigned FLASH_BYTES = 65536,
    parameter int unsigned SEG_COUNT   = 64,
    localparam int unsigned ADDR_W = $clog2(FLASH_BYTES),
    localparam int unsigned SEG_W  = $clog2(SEG_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEG_COUNT-1:0] cfg_fetch_only,
    input  logic [SEG_COUNT-1:0] cfg_priv_only,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_fetch,
    input  logic                 req_priv,
    output logic                 fl_rd_en,
    output logic [ADDR_W-1:0]    fl_addr,
    input  logic [31:0]          fl_rdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_data,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [7:0]           paddr,
    output logic [31:0]          prdata,
    output logic                 pslverr
);
    typedef struct packed {
        logic [SEG_COUNT-1:0] fetch_only;
        logic [SEG_COUNT-1:0] priv_only;
        logic                 rsp_valid;
        logic                 rsp_err;
    } guard_state_t;

    guard_state_t g_d, g_q;
    logic         deny;
    logic [SEG_W-1:0] seg_idx;

    assign seg_idx = req_addr[ADDR_W-1 -: SEG_W];

    seg_rule_check #(.SEG_COUNT(SEG_COUNT)) u_rule (
        .seg_idx    (seg_idx),
        .is_fetch   (req_fetch),
        .is_priv    (req_priv),
        .fetch_only (g_q.fetch_only),
        .priv_only  (g_q.priv_only),
        .deny       (deny)
    );

    always_comb begin
        g_d = g_q;
        if (!rst_n) begin
            g_d.fetch_only = cfg_fetch_only;
            g_d.priv_only  = cfg_priv_only;
            g_d.rsp_valid  = 1'b0;
            g_d.rsp_err    = 1'b0;
        end else begin
            g_d.rsp_valid = req_valid;
            g_d.rsp_err   = req_valid && deny;
        end
    end

    always_ff @(posedge clk) begin
        g_q <= g_d;
    end

    assign fl_rd_en  = rst_n && req_valid && !deny;
    assign fl_addr   = req_addr;
    assign rsp_valid = g_q.rsp_valid;
    assign rsp_err   = g_q.rsp_err;
    assign rsp_data  = (g_q.rsp_valid && !g_q.rsp_err) ? fl_rdata : '0;

    seg_reg_window #(
        .SEG_COUNT   (SEG_COUNT),
        .FLASH_BYTES (FLASH_BYTES),
        .PADDR_W     (8)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_only (g_q.fetch_only),
        .priv_only  (g_q.priv_only),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .prdata     (prdata),
        .pslverr    (pslverr)
    );

    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R5
    no_read_on_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(req_valid && !fl_rd_en));
endmodule

// File: tb/sim_flash_seg_guard.sv
module sim_flash_seg_guard;
    localparam int unsigned FB = 65536;

    typedef struct packed {
        logic [15:0] addr;
        logic        fetch;
        logic        priv;
        logic        deny;
    } vec_t;

    // segment = addr[15:10]; fetch-only segs 0,1,36..39; privileged-only segs 1,2,63
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h1400, 1'b0, 1'b0, 1'b0},  // R1 seg5 unprotected
        '{16'h0000, 1'b0, 1'b0, 1'b1},  // R2 seg0 data read
        '{16'h0004, 1'b1, 1'b0, 1'b0},  // R2 seg0 fetch
        '{16'h0400, 1'b1, 1'b0, 1'b1},  // R3 seg1 user fetch
        '{16'h0404, 1'b1, 1'b1, 1'b0},  // R3 seg1 priv fetch
        '{16'h0408, 1'b0, 1'b1, 1'b1},  // R2 seg1 priv data
        '{16'h0800, 1'b0, 1'b0, 1'b1},  // R3 seg2 user data
        '{16'h0810, 1'b0, 1'b1, 1'b0},  // R3 seg2 priv data
        '{16'hFC00, 1'b0, 1'b0, 1'b1},  // R3 seg63 user
        '{16'hFFFC, 1'b0, 1'b1, 1'b0},  // R3 seg63 priv, top byte range
        '{16'h9000, 1'b0, 1'b1, 1'b1},  // R2 seg36 data, high word bit
        '{16'h93FC, 1'b1, 1'b0, 1'b0},  // R2 seg36 fetch
        '{16'hA000, 1'b0, 1'b0, 1'b0},  // R1 seg40 just above fetch-only run
        '{16'h8FFC, 1'b0, 1'b0, 1'b0}   // R1 seg35 just below fetch-only run
    };

    localparam logic [63:0] FO_MASK = 64'h0000_00F0_0000_0003;
    localparam logic [63:0] PO_MASK = 64'h8000_0000_0000_0006;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cfg_fo = FO_MASK;
    logic [63:0] cfg_po = PO_MASK;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_fetch = 1'b0;
    logic        req_priv = 1'b0;
    logic        fl_rd_en, fl_rd_en1;
    logic [15:0] fl_addr, fl_addr1;
    logic [31:0] fl_rdata = '0;
    logic        rsp_valid, rsp_err, rsp_valid1, rsp_err1;
    logic [31:0] rsp_data, rsp_data1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] prdata, prdata1;
    logic        pslverr, pslverr1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_seg_guard #(.FLASH_BYTES(FB), .SEG_COUNT(64)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fetch_only(cfg_fo), .cfg_priv_only(cfg_po),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch), .req_priv(req_priv),
        .fl_rd_en(fl_rd_en), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .prdata(prdata), .pslverr(pslverr)
    );

    flash_seg_guard #(.FLASH_BYTES(FB), .SEG_COUNT(32)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_fetch_only(cfg_fo[31:0]), .cfg_priv_only(cfg_po[31:0]),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch), .req_priv(req_priv),
        .fl_rd_en(fl_rd_en1), .fl_addr(fl_addr1), .fl_rdata(fl_rdata),
        .rsp_valid(rsp_valid1), .rsp_err(rsp_err1), .rsp_data(rsp_data1),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .prdata(prdata1), .pslverr(pslverr1)
    );

    // flash model: data appears one cycle after the read strobe
    always_ff @(posedge clk) begin
        fl_rdata <= fl_rd_en ? {16'hA5A5, fl_addr} : 32'hDEAD_BEEF;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic reg_access(input logic wr, input logic [7:0] a,
                              output logic [31:0] d0, output logic e0,
                              output logic [31:0] d1, output logic e1);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d0 = prdata; e0 = pslverr; d1 = prdata1; e1 = pslverr1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic reg_expect(input logic [7:0] a, input logic [31:0] x0,
                              input logic [31:0] x1, input string tag);
        logic [31:0] d0, d1;
        logic e0, e1;
        reg_access(1'b0, a, d0, e0, d1, e1);
        chk({tag, " u0 data"}, d0, x0);
        chk({tag, " u0 err"}, 32'(e0), 32'd0);
        chk({tag, " u1 data"}, d1, x1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d0, d1;
        logic e0, e1;

        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 rsp_err", 32'(rsp_err), 32'd0);
        chk("R10 rsp_data", rsp_data, 32'd0);
        chk("R10 pslverr", 32'(pslverr), 32'd0);
        rst_n = 1'b1;
        // R6: port changes after reset must not reach the masks
        cfg_fo = '1;
        cfg_po = '1;
        @(negedge clk);
        chk("R4 idle no rsp", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = VECS[i].addr;
            req_fetch = VECS[i].fetch;
            req_priv  = VECS[i].priv;
            #1;
            chk($sformatf("R5 fl_rd_en v%0d", i), 32'(fl_rd_en), 32'(!VECS[i].deny));
            @(negedge clk);
            req_valid = 1'b0;
            chk($sformatf("R4 rsp_valid v%0d", i), 32'(rsp_valid), 32'd1);
            chk($sformatf("R2/R3 rsp_err v%0d", i), 32'(rsp_err), 32'(VECS[i].deny));
            chk($sformatf("R4/R5 rsp_data v%0d", i), rsp_data,
                VECS[i].deny ? 32'd0 : {16'hA5A5, VECS[i].addr});
        end

        // R4: back-to-back requests, denied then allowed
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0010; req_fetch = 1'b0; req_priv = 1'b1;
        @(negedge clk);
        req_addr = 16'h1420;
        chk("R4 b2b first err", 32'(rsp_err), 32'd1);
        chk("R5 b2b first data", rsp_data, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 b2b second valid", 32'(rsp_valid), 32'd1);
        chk("R4 b2b second data", rsp_data, 32'hA5A5_1420);
        @(negedge clk);
        chk("R4 no rsp after b2b", 32'(rsp_valid), 32'd0);

        // R1 with 32 segments: addr 0x0800 is seg1 (2 KiB segments), fetch-only+priv-only
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0800; req_fetch = 1'b1; req_priv = 1'b1;
        #1;
        chk("R1 u1 seg1 priv fetch rd_en", 32'(fl_rd_en1), 32'd1);
        req_fetch = 1'b0;
        #1;
        chk("R1 u1 seg1 data rd_en", 32'(fl_rd_en1), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;

        // R7: register map, both instances
        reg_expect(8'h18, 32'h0000_00F0, 32'd0, "R7 fetch hi");
        reg_expect(8'h1C, 32'h0000_0003, 32'h0000_0003, "R7 fetch lo");
        reg_expect(8'h20, 32'h8000_0000, 32'd0, "R7 priv hi");
        reg_expect(8'h24, 32'h0000_0006, 32'h0000_0006, "R7 priv lo");
        reg_expect(8'h28, 32'h000A_0040, 32'h000B_0020, "R7 config");
        reg_expect(8'h00, 32'd0, 32'd0, "R7 reserved low");
        reg_expect(8'h2B, 32'h000A_0040, 32'h000B_0020, "R7 last byte");

        // R8: beyond the window
        reg_access(1'b0, 8'h2C, d0, e0, d1, e1);
        chk("R8 read 0x2C err", 32'(e0), 32'd1);
        chk("R8 read 0x2C data", d0, 32'd0);
        chk("R8 read 0x2C err u1", 32'(e1), 32'd1);
        reg_access(1'b1, 8'h40, d0, e0, d1, e1);
        chk("R8 write 0x40 err", 32'(e0), 32'd1);

        // R9: writes change nothing and read zero
        reg_access(1'b1, 8'h1C, d0, e0, d1, e1);
        chk("R9 write data", d0, 32'd0);
        chk("R9 write err", 32'(e0), 32'd0);
        reg_expect(8'h1C, 32'h0000_0003, 32'h0000_0003, "R9 after write");

        // R6: masks still the reset-time values (ports are all ones now)
        reg_expect(8'h24, 32'h0000_0006, 32'h0000_0006, "R6 priv lo kept");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule